// File: doc/BRIEF.md
# Serial Hex Register Command Bridge

This block lets a host reach an on-chip register space over a two-wire asynchronous serial link. The host types short ASCII commands. A write gives an address and a value in hexadecimal. A read gives only an address, and the block answers with the register value as text. Each complete command becomes exactly one single-word access on a simple bus master port with cycle, strobe, write-enable and acknowledge signals. Both address and data are 16 bits.

The block contains its own serial receiver and transmitter, and both share one oversampling enable. It also contains the command grammar walker, the bus master, and a text formatter. The formatter sends a fixed greeting after reset and the read replies. Until the greeting has been fully handed to the transmitter, all received characters are dropped.

Internally, the formatter passes characters to the transmitter over a valid/ready pair. A character is taken on a clock where both are high. The formatter holds valid and the character steady while ready is low. The receiver raises a one-clock valid pulse for each byte. Its consumer never stalls, so that path has no ready signal.

Top module: `uart_regcmd_top`

## Requirements
- R1: While reset is asserted, the transmit line is high and bus cycle and strobe are low.
- R2: After reset the transmit line carries the seven bytes "READY", 0x0D, 0x0A. No bus access happens, and any characters received, are dropped until the last of these bytes has been accepted for transmission.
- R3: Every transmitted byte is framed as one low start bit, eight data bits least significant first, and two high stop bits. Each bit lasts 16*(PRESCALE+1) clocks. The receiver expects the same framing and bit time.
- R4: The sequence 'W', space, four hex address digits, space, four hex data digits, space produces one bus cycle with write-enable high and the given address and data. The most significant digit comes first.
- R5: The sequence 'R', space, four hex address digits, space produces one bus cycle with write-enable low and the given address.
- R6: After a read is acknowledged, the value captured on the read data port is sent as four upper-case hex digits, most significant first, followed by 0x0D and 0x0A.
- R7: Hex digits 0-9, A-F and a-f are all accepted in address and data fields.
- R8: Any character that does not fit the grammar at its position drops the partial command with no bus access. This includes a missing final space. The next well-formed command is handled normally.
- R9: Cycle, strobe, write-enable, address and write data stay unchanged while acknowledge is low. Cycle and strobe fall on the clock after the acknowledge is seen.
- R10: A low pulse on the receive line that has ended by the middle of a start bit produces no byte. A command split around such a pulse still executes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| uart_rx | input | 1 | Serial receive line, idles high |
| uart_tx | output | 1 | Serial transmit line, idles high |
| bus_cyc | output | 1 | Bus cycle active |
| bus_stb | output | 1 | Bus strobe, high together with cycle |
| bus_we | output | 1 | Write enable of the current cycle |
| bus_adr | output | 16 | Access address |
| bus_wdat | output | 16 | Write data |
| bus_rdat | input | 16 | Read data, captured on acknowledge |
| bus_ack | input | 1 | Access acknowledge from the slave |

## Verification
A bus cycle starts about five clocks after the middle of the final space's first stop bit: two synchronizer stages, the receiver register, then the parser register. The bench gives each access a window of one character time and does not pin the exact edge. The cycle ends on the clock after acknowledge. The bench's slave acknowledges three clocks after strobe, and the bench checks on every falling clock edge that the cycle is gone one sample after acknowledge and that the address has not moved. The reply's first start bit begins three clocks after the read acknowledge. The bench decodes the transmit line at bit midpoints, so its byte checks depend only on bit time. It waits up to ten character times for each reply and compares every character with hex digits it computes from the address it sent.

// File: rtl/uart_regcmd_pkg.sv
package uart_regcmd_pkg;

  typedef enum logic [1:0] {RX_IDLE, RX_START, RX_BITS, RX_STOP} rx_state_t;

  typedef enum logic [2:0] {
    PS_IDLE, PS_SEP0, PS_ADDR, PS_SEP1, PS_DATA, PS_SEP2, PS_BUS, PS_REPLY
  } parse_state_t;

  typedef enum logic [1:0] {FS_BANNER, FS_IDLE, FS_REPLY} fmt_state_t;

  localparam logic [7:0] CH_SPACE = 8'h20;
  localparam logic [7:0] CH_CR    = 8'h0D;
  localparam logic [7:0] CH_LF    = 8'h0A;

  // {valid, value}
  function automatic logic [4:0] hex_decode(input logic [7:0] c);
    logic [4:0] r;
    r = 5'b0;
    if (c >= 8'h30 && c <= 8'h39) r = {1'b1, c[3:0]};
    else if ((c >= 8'h41 && c <= 8'h46) || (c >= 8'h61 && c <= 8'h66))
      r = {1'b1, c[3:0] + 4'd9};
    return r;
  endfunction

  function automatic logic [7:0] hex_encode(input logic [3:0] n);
    return (n < 4'd10) ? (8'h30 + {4'h0, n}) : (8'h37 + {4'h0, n});
  endfunction

endpackage

// File: rtl/uart_rx_os.sv
module uart_rx_os (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       tick,
  input  logic       line,
  output logic       out_valid,
  output logic [7:0] out_data
);
  import uart_regcmd_pkg::*;

  rx_state_t  st;
  logic [3:0] tcnt;
  logic [2:0] bcnt;
  logic [7:0] shreg;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st        <= RX_IDLE;
      tcnt      <= '0;
      bcnt      <= '0;
      shreg     <= '0;
      out_valid <= 1'b0;
      out_data  <= '0;
    end else begin
      out_valid <= 1'b0;
      if (tick) begin
        case (st)
          RX_IDLE: if (!line) begin
            st   <= RX_START;
            tcnt <= '0;
          end
          RX_START: begin
            if (tcnt == 4'd7) begin
              tcnt <= '0;
              bcnt <= '0;
              st   <= line ? RX_IDLE : RX_BITS;
            end else tcnt <= tcnt + 4'd1;
          end
          RX_BITS: begin
            if (tcnt == 4'd15) begin
              tcnt  <= '0;
              shreg <= {line, shreg[7:1]};
              bcnt  <= bcnt + 3'd1;
              if (bcnt == 3'd7) st <= RX_STOP;
            end else tcnt <= tcnt + 4'd1;
          end
          default: begin
            if (tcnt == 4'd15) begin
              st <= RX_IDLE;
              if (line) begin
                out_valid <= 1'b1;
                out_data  <= shreg;
              end
            end else tcnt <= tcnt + 4'd1;
          end
        endcase
      end
    end
  end

  a_r10_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |=> !out_valid);

endmodule

// File: rtl/uart_tx_os.sv
module uart_tx_os (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       tick,
  input  logic       in_valid,
  input  logic [7:0] in_data,
  output logic       in_ready,
  output logic       line
);
  localparam int NBITS = 11;

  logic             busy;
  logic [NBITS-1:0] shreg;
  logic [3:0]       tcnt;
  logic [3:0]       bcnt;

  assign in_ready = !busy;
  assign line     = busy ? shreg[0] : 1'b1;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy  <= 1'b0;
      shreg <= '1;
      tcnt  <= '0;
      bcnt  <= '0;
    end else if (!busy) begin
      if (in_valid) begin
        busy  <= 1'b1;
        shreg <= {2'b11, in_data, 1'b0};
        tcnt  <= '0;
        bcnt  <= '0;
      end
    end else if (tick) begin
      if (tcnt == 4'd15) begin
        tcnt  <= '0;
        shreg <= {1'b1, shreg[NBITS-1:1]};
        bcnt  <= bcnt + 4'd1;
        if (bcnt == 4'(NBITS - 1)) busy <= 1'b0;
      end else tcnt <= tcnt + 4'd1;
    end
  end

  a_r3_accept_starts_frame: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready) |=> (!in_ready && !line));

endmodule

// File: rtl/regcmd_parser.sv
module regcmd_parser #(
  parameter int AW = 16,
  parameter int DW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          enable,
  input  logic          in_valid,
  input  logic [7:0]    in_data,
  output logic          bus_cyc,
  output logic          bus_we,
  output logic [AW-1:0] bus_adr,
  output logic [DW-1:0] bus_wdat,
  input  logic [DW-1:0] bus_rdat,
  input  logic          bus_ack,
  output logic          reply_req,
  output logic [DW-1:0] reply_val,
  input  logic          reply_done
);
  import uart_regcmd_pkg::*;

  localparam int NA  = AW / 4;
  localparam int ND  = DW / 4;
  localparam int NMX = (NA > ND) ? NA : ND;
  localparam int DGW = (NMX > 1) ? $clog2(NMX) : 1;

  parse_state_t   st;
  logic [DGW-1:0] dig;
  logic [4:0]     hx;

  assign hx = hex_decode(in_data);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st        <= PS_IDLE;
      dig       <= '0;
      bus_cyc   <= 1'b0;
      bus_we    <= 1'b0;
      bus_adr   <= '0;
      bus_wdat  <= '0;
      reply_req <= 1'b0;
      reply_val <= '0;
    end else begin
      reply_req <= 1'b0;
      case (st)
        PS_BUS: if (bus_ack) begin
          bus_cyc <= 1'b0;
          if (bus_we) st <= PS_IDLE;
          else begin
            reply_val <= bus_rdat;
            reply_req <= 1'b1;
            st        <= PS_REPLY;
          end
        end
        PS_REPLY: if (reply_done) st <= PS_IDLE;
        default: if (in_valid && enable) begin
          st <= PS_IDLE;
          case (st)
            PS_IDLE: begin
              if (in_data == 8'h57 || in_data == 8'h52) begin
                bus_we <= (in_data == 8'h57);
                st     <= PS_SEP0;
              end
            end
            PS_SEP0: if (in_data == CH_SPACE) begin
              st  <= PS_ADDR;
              dig <= '0;
            end
            PS_ADDR: if (hx[4]) begin
              bus_adr <= {bus_adr[AW-5:0], hx[3:0]};
              dig     <= dig + 1'b1;
              st      <= (dig == DGW'(NA - 1)) ? PS_SEP1 : PS_ADDR;
            end
            PS_SEP1: if (in_data == CH_SPACE) begin
              if (bus_we) begin
                st  <= PS_DATA;
                dig <= '0;
              end else begin
                st      <= PS_BUS;
                bus_cyc <= 1'b1;
              end
            end
            PS_DATA: if (hx[4]) begin
              bus_wdat <= {bus_wdat[DW-5:0], hx[3:0]};
              dig      <= dig + 1'b1;
              st       <= (dig == DGW'(ND - 1)) ? PS_SEP2 : PS_DATA;
            end
            PS_SEP2: if (in_data == CH_SPACE) begin
              st      <= PS_BUS;
              bus_cyc <= 1'b1;
            end
            default: st <= PS_IDLE;
          endcase
        end
      endcase
    end
  end

  a_r9_hold_until_ack: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_cyc && !bus_ack) |=> (bus_cyc && $stable(bus_adr) && $stable(bus_wdat) && $stable(bus_we)));

  a_r9_drop_after_ack: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_cyc && bus_ack) |=> !bus_cyc);

  a_r6_reply_only_reads: assert property (@(posedge clk) disable iff (!rst_n)
    reply_req |-> (!bus_we && !bus_cyc));

endmodule

// File: rtl/reply_fmt.sv
module reply_fmt #(
  parameter int DW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          req,
  input  logic [DW-1:0] val,
  output logic          tx_valid,
  output logic [7:0]    tx_data,
  input  logic          tx_ready,
  output logic          banner_done,
  output logic          done
);
  import uart_regcmd_pkg::*;

  localparam int ND     = DW / 4;
  localparam int BLEN   = 7;
  localparam int RLEN   = ND + 2;
  localparam int MAXLEN = (RLEN > BLEN) ? RLEN : BLEN;
  localparam int IW     = $clog2(MAXLEN);

  fmt_state_t     st;
  logic [IW-1:0]  idx;
  logic [DW-1:0]  val_r;
  logic [3:0]     nib;
  logic           last;

  always_comb begin
    nib = 4'h0;
    for (int k = 0; k < ND; k++)
      if (idx == IW'(k)) nib = val_r[DW-1-4*k -: 4];
  end

  always_comb begin
    tx_data = CH_LF;
    if (st == FS_BANNER) begin
      case (idx)
        IW'(0): tx_data = 8'h52;
        IW'(1): tx_data = 8'h45;
        IW'(2): tx_data = 8'h41;
        IW'(3): tx_data = 8'h44;
        IW'(4): tx_data = 8'h59;
        IW'(5): tx_data = CH_CR;
        default: tx_data = CH_LF;
      endcase
    end else if (idx < IW'(ND)) tx_data = hex_encode(nib);
    else if (idx == IW'(ND)) tx_data = CH_CR;
  end

  assign tx_valid = (st != FS_IDLE);
  assign last     = (st == FS_BANNER) ? (idx == IW'(BLEN - 1)) : (idx == IW'(RLEN - 1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st          <= FS_BANNER;
      idx         <= '0;
      val_r       <= '0;
      banner_done <= 1'b0;
      done        <= 1'b0;
    end else begin
      done <= 1'b0;
      if (st == FS_IDLE) begin
        if (req) begin
          val_r <= val;
          idx   <= '0;
          st    <= FS_REPLY;
        end
      end else if (tx_ready) begin
        if (last) begin
          st <= FS_IDLE;
          if (st == FS_BANNER) banner_done <= 1'b1;
          else done <= 1'b1;
        end else idx <= idx + 1'b1;
      end
    end
  end

  a_r2_banner_once: assert property (@(posedge clk) disable iff (!rst_n)
    banner_done |=> banner_done);

  a_r6_char_held: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_valid && !tx_ready) |=> (tx_valid && $stable(tx_data)));

endmodule

// File: rtl/uart_regcmd_top.sv
module uart_regcmd_top #(
  parameter int PRESCALE = 3,
  parameter int AW       = 16,
  parameter int DW       = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          uart_rx,
  output logic          uart_tx,
  output logic          bus_cyc,
  output logic          bus_stb,
  output logic          bus_we,
  output logic [AW-1:0] bus_adr,
  output logic [DW-1:0] bus_wdat,
  input  logic [DW-1:0] bus_rdat,
  input  logic          bus_ack
);
  localparam int PW = (PRESCALE > 0) ? $clog2(PRESCALE + 1) : 1;

  logic [PW-1:0] pre_cnt;
  logic          tick;
  logic [1:0]    rx_sync;
  logic          rxb_valid;
  logic [7:0]    rxb_data;
  logic          ch_valid, ch_ready;
  logic [7:0]    ch_data;
  logic          reply_req, reply_done, banner_done;
  logic [DW-1:0] reply_val;

  assign tick = (pre_cnt == PW'(PRESCALE));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pre_cnt <= '0;
      rx_sync <= 2'b11;
    end else begin
      pre_cnt <= tick ? '0 : pre_cnt + 1'b1;
      rx_sync <= {rx_sync[0], uart_rx};
    end
  end

  uart_rx_os u_rx (
    .clk(clk), .rst_n(rst_n), .tick(tick), .line(rx_sync[1]),
    .out_valid(rxb_valid), .out_data(rxb_data)
  );

  regcmd_parser #(.AW(AW), .DW(DW)) u_parse (
    .clk(clk), .rst_n(rst_n), .enable(banner_done),
    .in_valid(rxb_valid), .in_data(rxb_data),
    .bus_cyc(bus_cyc), .bus_we(bus_we), .bus_adr(bus_adr), .bus_wdat(bus_wdat),
    .bus_rdat(bus_rdat), .bus_ack(bus_ack),
    .reply_req(reply_req), .reply_val(reply_val), .reply_done(reply_done)
  );

  reply_fmt #(.DW(DW)) u_fmt (
    .clk(clk), .rst_n(rst_n), .req(reply_req), .val(reply_val),
    .tx_valid(ch_valid), .tx_data(ch_data), .tx_ready(ch_ready),
    .banner_done(banner_done), .done(reply_done)
  );

  uart_tx_os u_tx (
    .clk(clk), .rst_n(rst_n), .tick(tick),
    .in_valid(ch_valid), .in_data(ch_data), .in_ready(ch_ready), .line(uart_tx)
  );

  assign bus_stb = bus_cyc;

  a_r2_no_bus_before_banner: assert property (@(posedge clk) disable iff (!rst_n)
    !banner_done |-> !bus_cyc);

  a_r6_reply_waits_idle: assert property (@(posedge clk) disable iff (!rst_n)
    reply_req |-> !ch_valid);

endmodule

// File: tb/tb_uart_regcmd_top.sv
`timescale 1ns/1ps
module tb_uart_regcmd_top;
  localparam int PRE = 1;
  localparam int BIT = 16 * (PRE + 1);
  localparam int CHR = 11 * BIT;

  logic clk = 1'b0, rst_n = 1'b0, rx = 1'b1;
  logic uart_tx, bus_cyc, bus_stb, bus_we, bus_ack = 1'b0;
  logic [15:0] bus_adr, bus_wdat, bus_rdat;

  int checks = 0, errors = 0;
  int acc_n = 0, wcnt = 0, rlog_n = 0, frame_errs = 0, hold_errs = 0;
  logic [15:0] acc_adr = '0, acc_dat = '0;
  logic acc_we = 1'b0;
  logic [7:0] rlog [0:255];
  logic p_ack = 1'b0, p_cyc = 1'b0;
  logic [15:0] p_adr = '0;

  assign bus_rdat = bus_adr ^ 16'h5A3C;

  uart_regcmd_top #(.PRESCALE(PRE)) dut (
    .clk(clk), .rst_n(rst_n), .uart_rx(rx), .uart_tx(uart_tx),
    .bus_cyc(bus_cyc), .bus_stb(bus_stb), .bus_we(bus_we), .bus_adr(bus_adr),
    .bus_wdat(bus_wdat), .bus_rdat(bus_rdat), .bus_ack(bus_ack)
  );

  always #2 clk = ~clk;

  // bus slave: acknowledge three clocks after strobe
  always @(posedge clk) begin
    if (!rst_n) begin
      bus_ack <= 1'b0;
      wcnt    <= 0;
    end else begin
      bus_ack <= 1'b0;
      if (bus_cyc && bus_stb && !bus_ack) begin
        if (wcnt == 2) begin
          bus_ack <= 1'b1;
          wcnt    <= 0;
          acc_n   <= acc_n + 1;
          acc_adr <= bus_adr;
          acc_dat <= bus_wdat;
          acc_we  <= bus_we;
        end else wcnt <= wcnt + 1;
      end
    end
  end

  // R9 monitor
  always @(negedge clk) begin
    if (rst_n) begin
      if (p_ack && bus_cyc) hold_errs = hold_errs + 1;
      if (p_cyc && bus_cyc && bus_adr != p_adr) hold_errs = hold_errs + 1;
    end
    p_ack = bus_ack;
    p_cyc = bus_cyc;
    p_adr = bus_adr;
  end

  // serial decoder of the transmit line (R3)
  initial begin
    forever begin
      @(negedge clk);
      if (rst_n && uart_tx == 1'b0) begin
        logic [7:0] b;
        logic ok;
        ok = 1'b1;
        repeat (BIT / 2 - 1) @(negedge clk);
        if (uart_tx != 1'b0) ok = 1'b0;
        for (int i = 0; i < 8; i++) begin
          repeat (BIT) @(negedge clk);
          b[i] = uart_tx;
        end
        repeat (BIT) @(negedge clk);
        if (uart_tx != 1'b1) ok = 1'b0;
        repeat (BIT) @(negedge clk);
        if (uart_tx != 1'b1) ok = 1'b0;
        if (!ok) frame_errs = frame_errs + 1;
        rlog[rlog_n[7:0]] = b;
        rlog_n = rlog_n + 1;
      end
    end
  end

  task automatic check(input bit cond, input string req, input int act, input int exp);
    checks++;
    if (!cond) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic send_byte(input logic [7:0] b);
    rx = 1'b0;
    repeat (BIT) @(negedge clk);
    for (int i = 0; i < 8; i++) begin
      rx = b[i];
      repeat (BIT) @(negedge clk);
    end
    rx = 1'b1;
    repeat (2 * BIT) @(negedge clk);
  endtask

  task automatic send_str(input string s);
    for (int i = 0; i < s.len(); i++) send_byte(s[i]);
  endtask

  task automatic wait_acc(input int target);
    for (int t = 0; t < CHR && acc_n < target; t++) @(negedge clk);
  endtask

  task automatic wait_bytes(input int target);
    for (int t = 0; t < 10 * CHR && rlog_n < target; t++) @(negedge clk);
  endtask

  function automatic logic [7:0] hexch(input int n);
    return (n < 10) ? 8'(48 + n) : 8'(55 + n);
  endfunction

  task automatic check_reply(input int base, input logic [15:0] v, input string req);
    wait_bytes(base + 6);
    check(rlog_n == base + 6, req, rlog_n, base + 6);
    for (int k = 0; k < 4; k++) begin
      int nib;
      nib = int'(v >> (12 - 4 * k)) & 15;
      check(rlog[base + k] == hexch(nib), req, rlog[base + k], hexch(nib));
    end
    check(rlog[base + 4] == 8'h0D && rlog[base + 5] == 8'h0A, req,
          {rlog[base + 4], rlog[base + 5]}, 16'h0D0A);
  endtask

  task automatic finish_run();
    check(frame_errs == 0, "R3 framing", frame_errs, 0);
    check(hold_errs == 0, "R9 hold/drop", hold_errs, 0);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    int base, n;
    string bn;
    repeat (5) @(negedge clk);
    check(uart_tx == 1'b1, "R1 tx idle in reset", uart_tx, 1);
    check(bus_cyc == 1'b0 && bus_stb == 1'b0, "R1 bus idle in reset", bus_cyc, 0);
    rst_n = 1'b1;

    // R2: command during banner is dropped
    send_str("W 1111 2222 ");
    wait_bytes(7);
    bn = "READY";
    for (int i = 0; i < 5; i++) check(rlog[i] == bn[i], "R2 banner", rlog[i], bn[i]);
    check(rlog[5] == 8'h0D && rlog[6] == 8'h0A, "R2 banner end", {rlog[5], rlog[6]}, 16'h0D0A);
    repeat (2 * CHR) @(negedge clk);
    check(acc_n == 0, "R2 no access during banner", acc_n, 0);

    // R4 write
    send_str("W 1234 ABCD ");
    wait_acc(1);
    check(acc_n == 1 && acc_we && acc_adr == 16'h1234, "R4 write addr", acc_adr, 16'h1234);
    check(acc_dat == 16'hABCD, "R4 write data", acc_dat, 16'hABCD);

    // R5/R6 read
    base = rlog_n;
    send_str("R 00F0 ");
    wait_acc(2);
    check(acc_n == 2 && !acc_we && acc_adr == 16'h00F0, "R5 read addr", acc_adr, 16'h00F0);
    check_reply(base, 16'h00F0 ^ 16'h5A3C, "R6 reply");

    // R7 lower case
    send_str("W beef c0de ");
    wait_acc(3);
    check(acc_we && acc_adr == 16'hBEEF && acc_dat == 16'hC0DE, "R7 lower write", acc_dat, 16'hC0DE);
    base = rlog_n;
    send_str("R ab12 ");
    wait_acc(4);
    check(acc_adr == 16'hAB12, "R7 lower read", acc_adr, 16'hAB12);
    check_reply(base, 16'hAB12 ^ 16'h5A3C, "R6 R7 upper reply");

    // R8 bad digit, missing space
    send_str("W 12G4 5678 ");
    send_str("R 0005X");
    repeat (2 * CHR) @(negedge clk);
    check(acc_n == 4, "R8 aborted commands", acc_n, 4);
    send_str("W 0001 0002 ");
    wait_acc(5);
    check(acc_adr == 16'h0001 && acc_dat == 16'h0002, "R8 recovery", acc_adr, 16'h0001);

    // R10 short low pulse inside a command
    send_str("W 12");
    rx = 1'b0;
    repeat (4) @(negedge clk);
    rx = 1'b1;
    repeat (14 * BIT) @(negedge clk);
    send_str("34 5678 ");
    wait_acc(6);
    check(acc_n == 6 && acc_adr == 16'h1234 && acc_dat == 16'h5678, "R10 glitch ignored", acc_dat, 16'h5678);

    // sweep of every hex digit in reads (R5 R6 R7)
    n = 6;
    for (int d = 0; d < 16; d++) begin
      logic [7:0] c;
      logic [15:0] a;
      c = (d >= 10 && d[0]) ? 8'(87 + d) : hexch(d);
      a = {4{4'(d)}};
      base = rlog_n;
      send_byte("R");
      send_byte(" ");
      repeat (4) send_byte(c);
      send_byte(" ");
      n++;
      wait_acc(n);
      check(acc_n == n && !acc_we && acc_adr == a, "R5 sweep addr", acc_adr, a);
      check_reply(base, a ^ 16'h5A3C, "R6 sweep reply");
    end
    finish_run();
  end
endmodule